// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Clock Master)

This block turns parallel stereo PCM sample pairs into a serial audio stream. It produces three outputs: a bit clock, a word clock that tells left from right, and a data line. A producer hands over one left/right pair at a time through a valid/ready handshake. The pair waits in a single holding stage until the next frame boundary, where it is loaded into a 64-bit frame shifter. Each frame has two 32-bit slots, left first.

The block is the clock master. It makes the bit clock from a clock-enable strobe `tick`, and each strobe moves the bit clock by half a period. Static configuration inputs select the framing. With the first-bit delay set, the stream is standard I2S and the MSB trails the word-clock edge by one bit. With the delay clear, the stream is left-justified, or right-justified when the justify flag is also set. Further inputs set the word-clock and bit-clock polarity and the sample length: 16, 24 or 32 bits inside the fixed 32-bit slot. Configuration is expected to change only while `en` is low.

Top module: `pcm_i2s_tx`

## Requirements
- R1: `cfg_wlen` selects the sample length: 0 gives 16 bits, 1 gives 24 bits, 2 gives 32 bits, and 3 is treated as 32 bits. The sample is taken from the low bits of `in_left`/`in_right`, and slot positions that carry no sample bit are sent as 0.
- R2: With `cfg_first_delay`=0 and `cfg_rjust`=0, the sample MSB is sent in the first bit period of its slot, which is the period that begins at the word-clock change.
- R3: With `cfg_first_delay`=1, every slot bit is sent one bit period later than in R2. The last bit of the right slot goes out in the first bit period of the next frame, and the very first bit after enable is 0. In this mode `cfg_rjust` has no effect.
- R4: With `cfg_first_delay`=0 and `cfg_rjust`=1, the sample LSB is sent in the last bit period of its slot, and the leading slot positions are 0.
- R5: With `cfg_ws_pol`=0 the word clock is low during the left slot and high during the right slot. With `cfg_ws_pol`=1 the levels are swapped. The word clock changes only together with a data change.
- R6: The bit clock toggles on every `tick` while enabled. With `cfg_sck_inv`=0, data changes where the bit clock falls. With `cfg_sck_inv`=1, data changes where it rises. The inactive level equals `cfg_sck_inv`.
- R7: A frame is 64 bit periods: 32 for the left slot, then 32 for the right slot. The first data bit period after enable starts a frame.
- R8: `in_ready` is high exactly when the holding stage is empty. A pair is accepted in a cycle where `in_valid` and `in_ready` are both high, and it is consumed at the start of the next frame.
- R9: If the holding stage is empty when a frame starts, that frame carries zeros in both slots and `underflow` is high for exactly one cycle.
- R10: While `en` is low, `sdo` is 0, `sck` rests at its inactive level, `ws` shows the left-slot level, and framing restarts on the next enable. A pair already held is kept.
- R11: After reset, `sdo`=0, `sck`=`cfg_sck_inv`, `ws`=`cfg_ws_pol`, `in_ready`=1 and `underflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low idles the serial outputs |
| tick | input | 1 | Half-bit-period strobe |
| cfg_first_delay | input | 1 | One-bit MSB delay after word-clock change |
| cfg_ws_pol | input | 1 | Word-clock level swap |
| cfg_sck_inv | input | 1 | Bit-clock inversion |
| cfg_rjust | input | 1 | Right-justify samples in their slot |
| cfg_wlen | input | 2 | Sample length code |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | 32 | Left sample |
| in_right | input | 32 | Right sample |
| in_ready | output | 1 | Holding stage empty |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word clock |
| sdo | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse on a zero-filled frame |

## Verification
The hardest case is the delayed mode with 32-bit samples. There the right-slot LSB spills into the first bit of the following frame, which depends on the frame before it and on the zero seeded at enable. The bench reaches it by running that mode with a `tick` on every cycle over several back-to-back frames, then re-enabling to check the seed. Underflow needs the holding stage empty at a frame boundary, so one phase switches the producer off. A short phase disables the block in the middle of a frame to check the restart.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SLOT_W  = 32;
    localparam int FRAME_W = 2 * SLOT_W;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_24  = 2'd1,
        WL_32  = 2'd2,
        WL_RSV = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  first_delay;
        logic  ws_pol;
        logic  sck_inv;
        logic  rjust;
        wlen_e wlen;
    } txcfg_t;

    function automatic int unsigned word_bits(input wlen_e wl);
        case (wl)
            WL_16:   return 16;
            WL_24:   return 24;
            default: return SLOT_W;
        endcase
    endfunction

    // Position a sample of the chosen length inside one slot; unused bits zero.
    function automatic logic [SLOT_W-1:0] place_word(input logic [SLOT_W-1:0] smp,
                                                     input wlen_e wl,
                                                     input logic rj);
        int unsigned       nb;
        logic [SLOT_W-1:0] mask;
        logic [SLOT_W-1:0] kept;
        nb   = word_bits(wl);
        mask = (nb >= SLOT_W) ? {SLOT_W{1'b1}} : ~({SLOT_W{1'b1}} << nb);
        kept = smp & mask;
        return rj ? kept : (kept << (SLOT_W - nb));
    endfunction

endpackage

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer #(
    parameter int FRAME_BITS = 64,
    parameter int IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    output logic             phase,
    output logic             active,
    output logic [IDX_W-1:0] bit_idx,
    output logic             launch,
    output logic             frame_start
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    assign launch      = en & tick & phase;
    assign frame_start = launch & (bit_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase   <= 1'b0;
            active  <= 1'b0;
            bit_idx <= LAST;
        end else begin
            if (tick) phase <= ~phase;
            if (launch) begin
                active  <= 1'b1;
                bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_pair_buffer.sv
module pcm_pair_buffer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] held_left,
    output logic [W-1:0] held_right
);
    assign in_ready = ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full       <= 1'b0;
            held_left  <= '0;
            held_right <= '0;
        end else begin
            if (take) full <= 1'b0;
            if (in_valid && in_ready) begin
                full       <= 1'b1;
                held_left  <= in_left;
                held_right <= in_right;
            end
        end
    end
endmodule

// File: rtl/i2s_frame_shifter.sv
module i2s_frame_shifter #(
    parameter int FRAME_BITS = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  launch,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_vec,
    input  logic                  delay,
    output logic                  sdo
);
    localparam int MSB = FRAME_BITS - 1;
    logic [FRAME_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (launch) begin
            if (load && delay) begin
                sdo <= sh[MSB];          // tail of previous frame
                sh  <= frame_vec;
            end else if (load) begin
                sdo <= frame_vec[MSB];
                sh  <= frame_vec << 1;
            end else begin
                sdo <= sh[MSB];
                sh  <= sh << 1;
            end
        end
    end
endmodule

// File: rtl/pcm_i2s_tx.sv
module pcm_i2s_tx
    import i2s_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        tick,
    input  logic        cfg_first_delay,
    input  logic        cfg_ws_pol,
    input  logic        cfg_sck_inv,
    input  logic        cfg_rjust,
    input  logic [1:0]  cfg_wlen,
    input  logic        in_valid,
    input  logic [31:0] in_left,
    input  logic [31:0] in_right,
    output logic        in_ready,
    output logic        sck,
    output logic        ws,
    output logic        sdo,
    output logic        underflow
);
    localparam int IDX_W = $clog2(FRAME_W);

    txcfg_t cfg;
    assign cfg = '{first_delay: cfg_first_delay, ws_pol: cfg_ws_pol,
                   sck_inv: cfg_sck_inv, rjust: cfg_rjust, wlen: wlen_e'(cfg_wlen)};

    logic             phase, active, launch, frame_start;
    logic [IDX_W-1:0] bit_idx;
    logic             hold_full;
    logic [SLOT_W-1:0] hold_l, hold_r;
    logic [SLOT_W-1:0] raw  [2];
    logic [SLOT_W-1:0] slot [2];
    logic [FRAME_W-1:0] frame_vec;
    logic             rj_eff;

    i2s_bit_timer #(.FRAME_BITS(FRAME_W)) u_timer (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .phase(phase), .active(active), .bit_idx(bit_idx),
        .launch(launch), .frame_start(frame_start)
    );

    pcm_pair_buffer #(.W(SLOT_W)) u_hold (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
        .take(frame_start), .full(hold_full),
        .held_left(hold_l), .held_right(hold_r)
    );

    assign rj_eff = cfg.rjust & ~cfg.first_delay;
    assign raw[0] = hold_l;
    assign raw[1] = hold_r;

    for (genvar c = 0; c < 2; c++) begin : g_slot
        assign slot[c] = place_word(raw[c], cfg.wlen, rj_eff);
    end

    assign frame_vec = hold_full ? {slot[0], slot[1]} : '0;

    i2s_frame_shifter #(.FRAME_BITS(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .en(en), .launch(launch), .load(frame_start),
        .frame_vec(frame_vec), .delay(cfg.first_delay), .sdo(sdo)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) underflow <= 1'b0;
        else            underflow <= frame_start & ~hold_full;
    end

    assign sck = phase ^ cfg.sck_inv;
    assign ws  = active ? ((bit_idx >= IDX_W'(SLOT_W)) ^ cfg.ws_pol) : cfg.ws_pol;
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic tick,
    input logic cfg_ws_pol,
    input logic cfg_sck_inv,
    input logic in_valid,
    input logic in_ready,
    input logic sck,
    input logic ws,
    input logic sdo,
    input logic underflow
);
    p_accept_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_uf_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !underflow);

    p_uf_left_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (ws == cfg_ws_pol));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sdo && (sck == cfg_sck_inv) && (ws == cfg_ws_pol) && !underflow));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> ($stable(sdo) && $stable(sck)));

    p_ws_launch_r5: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(ws)) |-> (sck == cfg_sck_inv));
endmodule

bind pcm_i2s_tx i2s_tx_checker u_chk (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .cfg_ws_pol(cfg_ws_pol), .cfg_sck_inv(cfg_sck_inv),
    .in_valid(in_valid), .in_ready(in_ready),
    .sck(sck), .ws(ws), .sdo(sdo), .underflow(underflow)
);

// File: tb/tb_pcm_i2s_tx.sv
module tb_pcm_i2s_tx;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, en, tick, cfg_first_delay, cfg_ws_pol, cfg_sck_inv, cfg_rjust;
    logic [1:0]  cfg_wlen;
    logic        in_valid;
    logic [31:0] in_left, in_right;
    logic        in_ready, sck, ws, sdo, underflow;

    pcm_i2s_tx dut (.*);

    int    checks = 0, fails = 0;
    string req_tag = "R11";
    bit    done = 0;
    int    tick_div = 2, tick_cnt = 0, feed_on = 0, k = 0;

    // behavioural reference state
    bit          mfull, mph, mact, msdo, muf, m_acc, rdy;
    int          mn;
    logic [31:0] ml, mr;
    bit          q[$];

    function automatic bit slot_bit(logic [31:0] s, int p);
        int nb;
        bit rj;
        nb = (cfg_wlen == 2'd0) ? 16 : (cfg_wlen == 2'd1) ? 24 : 32;
        rj = cfg_rjust && !cfg_first_delay;
        if (!rj) return (p < nb) ? s[nb-1-p] : 1'b0;
        return (p >= 32 - nb) ? s[31-p] : 1'b0;
    endfunction

    task automatic push_frame(bit have, logic [31:0] l, logic [31:0] r);
        for (int ch = 0; ch < 2; ch++)
            for (int p = 0; p < 32; p++)
                q.push_back(have ? slot_bit(ch == 0 ? l : r, p) : 1'b0);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mfull = 0; mph = 0; mact = 0; mn = -1; msdo = 0; muf = 0; m_acc = 0;
            q.delete();
        end else begin
            rdy = !mfull;
            m_acc = in_valid && rdy;
            muf = 0;
            if (!en) begin
                mph = 0; mact = 0; mn = -1; msdo = 0; q.delete();
            end else if (tick) begin
                if (!mph) mph = 1;
                else begin
                    mph = 0;
                    if (!mact) begin
                        mact = 1;
                        if (cfg_first_delay) q.push_back(1'b0);
                    end
                    mn++;
                    if (mn % 64 == 0) begin
                        push_frame(mfull, ml, mr);
                        if (!mfull) muf = 1;
                        mfull = 0;
                    end
                    msdo = q.pop_front();
                end
            end
            if (m_acc) begin mfull = 1; ml = in_left; mr = in_right; end
        end
    end

    task automatic check(string r, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", r, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({req_tag, " sdo"}, sdo, msdo);
            check("R6 sck", sck, mph ^ cfg_sck_inv);
            check("R5 ws", ws, mact ? (((mn % 64) >= 32) ^ cfg_ws_pol) : cfg_ws_pol);
            check("R8 in_ready", in_ready, !mfull);
            check("R9 underflow", underflow, muf);
        end
    end

    // strobe and producer
    initial begin
        tick = 0; in_valid = 0; in_left = 0; in_right = 0;
        forever begin
            @(posedge clk); #2;
            tick_cnt++;
            tick = (tick_div <= 1) ? 1'b1 : (tick_cnt % tick_div == 0);
            if (m_acc) k++;
            in_left  = 32'h9E3779B9 * (k + 1);
            in_right = ~in_left ^ (k * 32'h00010203);
            in_valid = (feed_on != 0);
        end
    end

    task automatic run_phase(string tag, bit d, bit pol, bit inv, bit rj, logic [1:0] wl,
                             int div, int feed, int ncyc);
        @(posedge clk); #2;
        cfg_first_delay = d; cfg_ws_pol = pol; cfg_sck_inv = inv;
        cfg_rjust = rj; cfg_wlen = wl; tick_div = div; feed_on = feed;
        req_tag = tag;
        @(posedge clk); #2;
        en = 1;
        repeat (ncyc) @(posedge clk);
        #2 en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 idle sdo", sdo, 1'b0);
        check("R10 idle sck", sck, inv);
        check("R10 idle ws", ws, pol);
    endtask

    initial begin
        rst = 1; en = 0; cfg_first_delay = 0; cfg_ws_pol = 0; cfg_sck_inv = 0;
        cfg_rjust = 0; cfg_wlen = 2'd2;
        repeat (5) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R11 sdo", sdo, 1'b0);
        check("R11 sck", sck, 1'b0);
        check("R11 ws", ws, 1'b0);
        check("R11 in_ready", in_ready, 1'b1);
        check("R11 underflow", underflow, 1'b0);

        run_phase("R2/R7", 0, 0, 0, 0, 2'd2, 2, 1, 800);
        run_phase("R3",    1, 0, 0, 1, 2'd0, 2, 1, 800);  // justify flag ignored
        run_phase("R3",    1, 1, 0, 0, 2'd2, 1, 1, 600);  // LSB carried to next frame
        run_phase("R4",    0, 0, 0, 1, 2'd1, 2, 1, 800);
        run_phase("R1",    0, 0, 0, 0, 2'd1, 3, 1, 900);
        run_phase("R5/R6", 0, 1, 1, 0, 2'd3, 2, 1, 800);
        run_phase("R9",    0, 0, 0, 0, 2'd2, 2, 0, 700);
        run_phase("R10",   1, 0, 1, 0, 2'd2, 2, 1, 150);  // cut mid-frame
        run_phase("R10",   1, 0, 1, 0, 2'd2, 2, 1, 400);  // restart after cut

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule